// File: doc/BRIEF.md
# Remote-Shared-Biased LRU Victim Selector

This block picks the way to evict from one set of a set-associative last-level cache in a multi-socket coherent system. It tracks an LRU age for each way. It also keeps a per-way flag for lines that were filled by a cache-to-cache transfer from another socket. When the bias is active, such lines are held back from eviction, so that hot data shared across sockets stays resident and does not cost another inter-socket transfer.

Protection is limited by two per-set counters. One counts protected lines whose home memory is on this socket. The other counts protected lines whose home memory is on another socket. When a counter reaches its threshold, the lines of that class are no longer protected and plain LRU order applies to them. A separate miss-event stream feeds a windowed monitor. At the end of each window, the monitor turns the bias on or off from the share of remote cache-to-cache misses.

The cache controller sends one event per cycle for the set: hit, fill or evict, together with the way index. For a fill it also sends whether the data came from a remote cache and whether the home memory of the line is remote. The controller reads the victim way combinationally whenever it has to allocate.

Top module: `rsb_victim_sel`

## Requirements
- R1: After reset, every way has age equal to its index, so the victim is way WAYS-1. No line is flagged, both counters are zero and bias_on is 0.
- R2: A hit (ev_op=0) or a fill (ev_op=1) makes the addressed way most recently used. Every way that was younger ages by one. Without protection, the victim is the oldest way.
- R3: An evict (ev_op=2) makes the addressed way least recently used. Every way that was older becomes younger by one.
- R4: When the WIN_LEN-th miss of a window arrives, bias_on becomes 1 in the next cycle if remote_misses*EN_DEN >= WIN_LEN*EN_NUM. With the defaults (8, 1, 2), this means at least 4 remote misses out of 8. Both window counters then restart.
- R5: bias_on changes only at a window end. It becomes 0 when a window ends with the ratio below the enable level.
- R6: While bias_on=1, a flagged way is skipped if the counter of its home class is below that class's threshold. The victim is the oldest way that is not protected.
- R7: While bias_on=0, the victim is the oldest way, whether it is flagged or not.
- R8: When a class counter equals its threshold, flagged ways of that class are not protected.
- R9: The local-home class and the remote-home class are counted and thresholded separately (ev_home_rem=1 means the home is remote).
- R10: A fill with ev_remote=1 sets the way's flag and increments its class counter only if that counter is below the class threshold. Otherwise the line is stored unflagged and the counter does not change.
- R11: An evict of a flagged way, or a fill over a flagged way, clears the flag and decrements the matching counter, which saturates at zero. This can restore protection for that class.
- R12: An event with ev_op=3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Set event present |
| ev_op | input | 2 | 0 hit, 1 fill, 2 evict, 3 no operation |
| ev_way | input | $clog2(WAYS) | Way addressed by the event |
| ev_remote | input | 1 | Fill data supplied by another socket's cache |
| ev_home_rem | input | 1 | Home memory of the filled line is on a remote socket |
| miss_valid | input | 1 | Miss event for window statistics |
| miss_remote | input | 1 | Miss was served by a remote cache-to-cache transfer |
| victim_way | output | $clog2(WAYS) | Way to evict, derived from the current set state |
| bias_on | output | 1 | Remote-shared protection active |

## Verification
A set event is registered on the clock edge that follows it. Because victim_way is purely combinational from the set state, it is due one edge after the event. The bench drives each event on a falling edge and checks the victim on the next falling edge, after the single state update. bias_on is a register loaded only by the last miss of a window, so it is due one edge after that miss. The bench checks it both after the second-to-last miss of a window, where it must be unchanged, and after the last miss, where it must take the new value.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
   typedef enum logic [1:0] {
      OP_HIT   = 2'd0,
      OP_FILL  = 2'd1,
      OP_EVICT = 2'd2,
      OP_NONE  = 2'd3
   } rsb_op_e;
endpackage

// File: rtl/rsb_lru_ages.sv
module rsb_lru_ages #(
   parameter int WAYS = 8,
   localparam int WW  = $clog2(WAYS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     touch,
   input  logic                     drop,
   input  logic [WW-1:0]            way,
   output logic [WAYS-1:0][WW-1:0]  age
);
   logic [WAYS-1:0][WW-1:0] age_nx;
   logic [WW-1:0]           ref_age;

   always_comb begin
      ref_age = age[way];
      age_nx  = age;
      for (int i = 0; i < WAYS; i++) begin
         if (touch) begin
            if (WW'(i) == way)            age_nx[i] = '0;
            else if (age[i] < ref_age)    age_nx[i] = age[i] + 1'b1;
         end else if (drop) begin
            if (WW'(i) == way)            age_nx[i] = WW'(WAYS - 1);
            else if (age[i] > ref_age)    age_nx[i] = age[i] - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WAYS; i++) age[i] <= WW'(i);
      end else begin
         age <= age_nx;
      end
   end

   logic [WAYS-1:0] is_oldest;
   always_comb begin
      for (int i = 0; i < WAYS; i++) is_oldest[i] = (age[i] == WW'(WAYS - 1));
   end

   logic          last_touch;
   logic [WW-1:0] last_way;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_touch <= 1'b0;
         last_way   <= '0;
      end else begin
         last_touch <= touch;
         last_way   <= way;
      end
   end

   // R2
   single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_oldest) == 1);
   // R2
   touched_is_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_touch |-> age[last_way] == '0);
endmodule

// File: rtl/rsb_prot_track.sv
module rsb_prot_track #(
   parameter int WAYS    = 8,
   parameter int THR_LOC = 2,
   parameter int THR_REM = 2,
   localparam int WW     = $clog2(WAYS),
   localparam int CW     = $clog2(WAYS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fill,
   input  logic                drop,
   input  logic [WW-1:0]       way,
   input  logic                remote,
   input  logic                home_rem,
   output logic [WAYS-1:0]     flag,
   output logic [WAYS-1:0]     cls_rem,
   output logic [CW-1:0]       cnt_loc,
   output logic [CW-1:0]       cnt_rem
);
   logic          rel_loc, rel_rem, grant;
   logic [CW-1:0] base_loc, base_rem, cnt_loc_nx, cnt_rem_nx;

   always_comb begin
      rel_loc  = (fill | drop) & flag[way] & ~cls_rem[way];
      rel_rem  = (fill | drop) & flag[way] &  cls_rem[way];
      base_loc = (rel_loc && cnt_loc != '0) ? cnt_loc - 1'b1 : cnt_loc;
      base_rem = (rel_rem && cnt_rem != '0) ? cnt_rem - 1'b1 : cnt_rem;
      grant    = fill & remote &
                 (home_rem ? (base_rem < CW'(THR_REM)) : (base_loc < CW'(THR_LOC)));
      cnt_loc_nx = base_loc + CW'(grant & ~home_rem);
      cnt_rem_nx = base_rem + CW'(grant &  home_rem);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag    <= '0;
         cls_rem <= '0;
         cnt_loc <= '0;
         cnt_rem <= '0;
      end else begin
         cnt_loc <= cnt_loc_nx;
         cnt_rem <= cnt_rem_nx;
         if (fill) begin
            flag[way]    <= grant;
            cls_rem[way] <= home_rem;
         end else if (drop) begin
            flag[way]    <= 1'b0;
         end
      end
   end

   logic          last_drop;
   logic [WW-1:0] last_way;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_drop <= 1'b0;
         last_way  <= '0;
      end else begin
         last_drop <= drop;
         last_way  <= way;
      end
   end

   // R10
   loc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_loc <= CW'(THR_LOC));
   // R10
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rem <= CW'(THR_REM));
   // R9
   loc_count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flag & ~cls_rem) == int'(cnt_loc));
   // R9
   rem_count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flag & cls_rem) == int'(cnt_rem));
   // R11
   evict_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_drop |-> !flag[last_way]);
endmodule

// File: rtl/rsb_window_mon.sv
module rsb_window_mon #(
   parameter int WIN_LEN = 8,
   parameter int EN_NUM  = 1,
   parameter int EN_DEN  = 2,
   localparam int MW     = $clog2(WIN_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic miss_valid,
   input  logic miss_remote,
   output logic bias_on
);
   logic [MW-1:0] tot_cnt, rem_cnt, rem_new;
   logic          win_end, meets;

   always_comb begin
      rem_new = rem_cnt + MW'(miss_remote);
      win_end = miss_valid && (tot_cnt == MW'(WIN_LEN - 1));
      meets   = (32'(rem_new) * 32'(EN_DEN)) >= (32'(WIN_LEN) * 32'(EN_NUM));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tot_cnt <= '0;
         rem_cnt <= '0;
         bias_on <= 1'b0;
      end else if (win_end) begin
         tot_cnt <= '0;
         rem_cnt <= '0;
         bias_on <= meets;
      end else if (miss_valid) begin
         tot_cnt <= tot_cnt + 1'b1;
         rem_cnt <= rem_new;
      end
   end

   // R5
   bias_moves_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bias_on) |-> $past(win_end));
   // R4
   window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tot_cnt < MW'(WIN_LEN) && rem_cnt <= tot_cnt);
endmodule

// File: rtl/rsb_victim_pick.sv
module rsb_victim_pick #(
   parameter int WAYS = 8,
   localparam int WW  = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][WW-1:0] age,
   input  logic [WAYS-1:0]         prot,
   output logic [WW-1:0]           victim
);
   logic          have_free;
   logic [WW-1:0] free_way, free_age, any_way, any_age;

   always_comb begin
      have_free = 1'b0;
      free_way  = '0;
      free_age  = '0;
      any_way   = '0;
      any_age   = age[0];
      for (int i = 0; i < WAYS; i++) begin
         if (age[i] > any_age) begin
            any_age = age[i];
            any_way = WW'(i);
         end
         if (!prot[i] && (!have_free || age[i] > free_age)) begin
            have_free = 1'b1;
            free_age  = age[i];
            free_way  = WW'(i);
         end
      end
      victim = have_free ? free_way : any_way;
   end
endmodule

// File: rtl/rsb_victim_sel.sv
module rsb_victim_sel #(
   parameter int WAYS    = 8,
   parameter int THR_LOC = 2,
   parameter int THR_REM = 2,
   parameter int WIN_LEN = 8,
   parameter int EN_NUM  = 1,
   parameter int EN_DEN  = 2,
   localparam int WW     = $clog2(WAYS),
   localparam int CW     = $clog2(WAYS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ev_valid,
   input  logic [1:0]    ev_op,
   input  logic [WW-1:0] ev_way,
   input  logic          ev_remote,
   input  logic          ev_home_rem,
   input  logic          miss_valid,
   input  logic          miss_remote,
   output logic [WW-1:0] victim_way,
   output logic          bias_on
);
   import rsb_pkg::*;

   if (WAYS < 2) begin : g_bad_ways
      $error("rsb_victim_sel: WAYS must be at least 2");
   end
   if (THR_LOC < 1 || THR_LOC > WAYS) begin : g_bad_thr_loc
      $error("rsb_victim_sel: THR_LOC must lie in 1..WAYS");
   end
   if (THR_REM < 1 || THR_REM > WAYS) begin : g_bad_thr_rem
      $error("rsb_victim_sel: THR_REM must lie in 1..WAYS");
   end
   if (WIN_LEN < 1 || EN_DEN < 1 || EN_NUM < 0 || EN_NUM > EN_DEN) begin : g_bad_win
      $error("rsb_victim_sel: window parameters out of range");
   end

   rsb_op_e op;
   logic    do_touch, do_fill, do_drop;

   always_comb begin
      op       = rsb_op_e'(ev_op);
      do_fill  = ev_valid && (op == OP_FILL);
      do_touch = ev_valid && (op == OP_HIT || op == OP_FILL);
      do_drop  = ev_valid && (op == OP_EVICT);
   end

   logic [WAYS-1:0][WW-1:0] age;
   logic [WAYS-1:0]         flag, cls_rem, prot;
   logic [CW-1:0]           cnt_loc, cnt_rem;
   logic                    loc_open, rem_open;

   rsb_lru_ages #(.WAYS(WAYS)) i_ages (
      .clk(clk), .rst_n(rst_n), .touch(do_touch), .drop(do_drop),
      .way(ev_way), .age(age));

   rsb_prot_track #(.WAYS(WAYS), .THR_LOC(THR_LOC), .THR_REM(THR_REM)) i_prot (
      .clk(clk), .rst_n(rst_n), .fill(do_fill), .drop(do_drop), .way(ev_way),
      .remote(ev_remote), .home_rem(ev_home_rem), .flag(flag), .cls_rem(cls_rem),
      .cnt_loc(cnt_loc), .cnt_rem(cnt_rem));

   rsb_window_mon #(.WIN_LEN(WIN_LEN), .EN_NUM(EN_NUM), .EN_DEN(EN_DEN)) i_win (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid),
      .miss_remote(miss_remote), .bias_on(bias_on));

   assign loc_open = cnt_loc < CW'(THR_LOC);
   assign rem_open = cnt_rem < CW'(THR_REM);

   for (genvar w = 0; w < WAYS; w++) begin : g_prot
      assign prot[w] = bias_on & flag[w] & (cls_rem[w] ? rem_open : loc_open);
   end

   rsb_victim_pick #(.WAYS(WAYS)) i_pick (
      .age(age), .prot(prot), .victim(victim_way));

   // R6
   victim_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~prot)) |-> !prot[victim_way]);
   // R7
   no_bias_no_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bias_on |-> age[victim_way] == WW'(WAYS - 1));
endmodule

// File: tb/test_rsb_victim_sel.sv
module test_rsb_victim_sel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_valid = 1'b0;
   logic [1:0] ev_op = 2'd0;
   logic [2:0] ev_way = 3'd0;
   logic       ev_remote = 1'b0;
   logic       ev_home_rem = 1'b0;
   logic       miss_valid = 1'b0;
   logic       miss_remote = 1'b0;
   logic [2:0] victim_way;
   logic       bias_on;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   rsb_victim_sel i_rsb_victim_sel (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op),
      .ev_way(ev_way), .ev_remote(ev_remote), .ev_home_rem(ev_home_rem),
      .miss_valid(miss_valid), .miss_remote(miss_remote),
      .victim_way(victim_way), .bias_on(bias_on));

   task automatic check(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic ev(input int op, input int way, input bit rem, input bit home);
      @(negedge clk);
      ev_valid = 1'b1; ev_op = 2'(op); ev_way = 3'(way);
      ev_remote = rem; ev_home_rem = home;
      @(negedge clk);
      ev_valid = 1'b0; ev_remote = 1'b0; ev_home_rem = 1'b0;
   endtask

   task automatic miss(input bit rem);
      @(negedge clk);
      miss_valid = 1'b1; miss_remote = rem;
      @(negedge clk);
      miss_valid = 1'b0; miss_remote = 1'b0;
   endtask

   task automatic enable_bias();
      for (int k = 0; k < 8; k++) miss(1'b1);
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R1 reset victim", int'(victim_way), 7);
      check("R1 reset bias", int'(bias_on), 0);
   endtask

   task automatic t_lru_basic();
      do_reset();
      ev(0, 7, 0, 0);
      check("R2 hit moves victim", int'(victim_way), 6);
      ev(1, 6, 0, 0);
      check("R2 fill moves victim", int'(victim_way), 5);
      ev(2, 0, 0, 0);
      check("R3 evict makes LRU", int'(victim_way), 0);
      ev(3, 0, 0, 0);
      check("R12 nop no effect", int'(victim_way), 0);
      ev(3, 5, 1, 1);
      check("R12 nop keeps order", int'(victim_way), 0);
   endtask

   task automatic t_window();
      do_reset();
      for (int k = 0; k < 7; k++) miss(k < 4);
      check("R5 bias held mid-window", int'(bias_on), 0);
      miss(1'b0);
      check("R4 bias enables at 4 of 8", int'(bias_on), 1);
      for (int k = 0; k < 7; k++) miss(k < 3);
      check("R5 bias held mid-window", int'(bias_on), 1);
      miss(1'b0);
      check("R5 bias disables at 3 of 8", int'(bias_on), 0);
   endtask

   task automatic t_plain_vs_bias();
      do_reset();
      ev(1, 3, 1, 0);
      for (int w = 0; w < 8; w++) if (w != 3) ev(0, w, 0, 0);
      check("R7 no bias picks flagged LRU", int'(victim_way), 3);
      do_reset();
      enable_bias();
      ev(1, 3, 1, 0);
      for (int w = 0; w < 8; w++) if (w != 3) ev(0, w, 0, 0);
      check("R6 bias skips flagged way", int'(victim_way), 0);
   endtask

   task automatic t_threshold();
      do_reset();
      enable_bias();
      ev(1, 5, 1, 0);
      ev(1, 3, 1, 0);
      ev(1, 4, 1, 0);
      ev(0, 0, 0, 0); ev(0, 1, 0, 0); ev(0, 2, 0, 0);
      ev(0, 6, 0, 0); ev(0, 7, 0, 0);
      check("R8 class at threshold unprotected", int'(victim_way), 5);
      ev(2, 3, 0, 0);
      check("R11 evicted flagged way is victim", int'(victim_way), 3);
      ev(0, 3, 0, 0);
      check("R10 over-threshold fill unprotected", int'(victim_way), 4);
   endtask

   task automatic t_classes();
      do_reset();
      enable_bias();
      ev(1, 5, 1, 1);
      ev(1, 3, 1, 0);
      ev(1, 4, 1, 0);
      ev(0, 0, 0, 0); ev(0, 1, 0, 0); ev(0, 2, 0, 0);
      ev(0, 6, 0, 0); ev(0, 7, 0, 0);
      check("R9 remote-home class still protected", int'(victim_way), 3);
   endtask

   initial begin
      t_reset_state();
      t_lru_basic();
      t_window();
      t_plain_vs_bias();
      t_threshold();
      t_classes();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule